// File: doc/BRIEF.md
# Two-way doorbell mailbox with channel-tagged words

The block joins two processor domains, called port 0 and port 1, with one small word queue in each direction. Each port sees the same register map. It has a receive window that pops from the queue the other side fills, and a status word for that queue. It has a send window that pushes into the queue the other side drains, and a status word for that queue. It also has an interrupt-enable register. A status word carries a full flag in bit 31 and an empty flag in bit 30.

A posted word is a 16-byte-aligned buffer address with a 4-bit channel number placed in its cleared low nibble. The block moves the word bit-exact, so the receiver can keep a word whose nibble matches the channel it expects and drop any other. Clearing the nibble gives back the buffer address. Channel 8 is the usual property channel.

Software polls the send status until the full flag is clear before it writes. It polls the receive status until the empty flag is clear before it reads. Each access is one cycle on a valid/ready register bus whose ready output is always high, and read data is returned in the same cycle as the request.

Top module: `mbx_doorbell`

## Requirements
- R1: After a synchronous active-low reset, both queues are empty. Every status word on both ports reads 0x4000_0000, both interrupt outputs are low, and a read of the receive window (offset 0x00) returns 0.
- R2: A status word has the full flag in bit 31 and the empty flag in bit 30, and every other bit reads 0. The receive status at offset 0x18 describes the queue that the port pops. The send status at offset 0x38 describes the queue that the port pushes.
- R3: A word written at offset 0x20 of one port is returned unchanged, in first-in first-out order, by reads at offset 0x00 of the other port. The low nibble (the channel) and the upper 28 bits (the address) are both preserved.
- R4: Each queue holds 8 words. With 8 words held, the full flag is set. A further write is dropped and leaves the queue and its flags as they were.
- R5: A read of the receive window while its queue is empty pops nothing. It returns the word most recently popped at that port, or 0 if no word has been popped since reset.
- R6: Each read of offset 0x00 on a non-empty queue pops exactly one word. Reads of the status and enable offsets pop nothing.
- R7: Bit 0 of offset 0x1C is the port's interrupt enable, and it reads back with all other bits 0. The port's interrupt output is high exactly when this bit is set and the port's receive queue is not empty.
- R8: Reads of unmapped offsets return 0. Writes to unmapped offsets, to the receive window and to the status offsets change no queue and no flag.
- R9: If a push and a pop hit the same queue in one cycle, the pop always proceeds. The push is kept only if the queue was not full before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| p0_valid | input | 1 | Port 0 request valid |
| p0_write | input | 1 | Port 0 request is a write (1) or a read (0) |
| p0_addr | input | 8 | Port 0 byte offset, word aligned |
| p0_wdata | input | 32 | Port 0 write data |
| p0_ready | output | 1 | Port 0 ready, always high |
| p0_rdata | output | 32 | Port 0 read data, valid in the request cycle |
| p0_irq | output | 1 | Port 0 receive-not-empty interrupt |
| p1_valid | input | 1 | Port 1 request valid |
| p1_write | input | 1 | Port 1 request is a write (1) or a read (0) |
| p1_addr | input | 8 | Port 1 byte offset, word aligned |
| p1_wdata | input | 32 | Port 1 write data |
| p1_ready | output | 1 | Port 1 ready, always high |
| p1_rdata | output | 32 | Port 1 read data, valid in the request cycle |
| p1_irq | output | 1 | Port 1 receive-not-empty interrupt |

## Verification
The assertions take for granted that only the owning port pops its receive queue, so a queue seen as non-empty cannot drain in the cycle in which the interrupt enable is written. They also assume that each port issues at most one request per cycle. The stimulus keeps to this because every task drives a single port request per cycle. The one exception is a dedicated sequence that drives a push on one port and a pop on the other in the same cycle to reach R9. Random traffic mixes sends, receives and status reads on both ports, and it deliberately overfills and overdrains the queues, since the block defines both cases.

// File: rtl/mbx_pkg.sv
// Shared constants for the doorbell mailbox: bus widths, register offsets
// and status flag positions. Assumes a 32-bit data bus with byte offsets.
package mbx_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned FULL_BIT  = 31;
    localparam int unsigned EMPTY_BIT = 30;

    localparam logic [ADDR_W-1:0] OFS_RX      = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RX_STAT = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_IRQ_EN  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_TX      = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_TX_STAT = 8'h38;

    // Build a status word from the two queue flags.
    function automatic logic [DATA_W-1:0] status_word(input logic full, input logic empty);
        logic [DATA_W-1:0] w;
        w            = '0;
        w[FULL_BIT]  = full;
        w[EMPTY_BIT] = empty;
        return w;
    endfunction
endpackage

// File: rtl/mbx_fifo.sv
// One-direction word queue. A push while full is dropped and a pop while
// empty is ignored. Full is judged on the count before the cycle, so a
// push and a pop on a full queue keep only the pop.
module mbx_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Store an accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Advance the pointers with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r4_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop |=> full && $stable(wr_ptr));
    a_r5_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop && !push |=> empty && $stable(rd_ptr));
    a_r9_pop_wins_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && pop |=> !full && !empty);
endmodule

// File: rtl/mbx_port.sv
// Register decode for one side of the mailbox. The side pops its receive
// queue, pushes its send queue and holds its interrupt enable and the last
// popped word. Assumes at most one request per cycle and a combinational
// read return.
module mbx_port
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] rx_head,
    input  logic              rx_full,
    input  logic              rx_empty,
    input  logic              tx_full,
    input  logic              tx_empty,
    output logic              rx_pop,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_data,
    output logic              irq
);
    logic              rd_hit, wr_hit;
    logic              irq_en;
    logic [DATA_W-1:0] last_rx;

    assign rd_hit  = valid && !write;
    assign wr_hit  = valid && write;
    assign rx_pop  = rd_hit && (addr == OFS_RX) && !rx_empty;
    assign tx_push = wr_hit && (addr == OFS_TX);
    assign tx_data = wdata;
    assign irq     = irq_en && !rx_empty;

    // Hold the interrupt enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                              irq_en <= 1'b0;
        else if (wr_hit && addr == OFS_IRQ_EN)   irq_en <= wdata[0];
    end

    // Remember the most recently popped word for reads while empty.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_rx <= '0;
        else if (rx_pop) last_rx <= rx_head;
    end

    // Return read data in the request cycle.
    always_comb begin
        rdata = '0;
        if (rd_hit) begin
            case (addr)
                OFS_RX:      rdata = rx_empty ? last_rx : rx_head;
                OFS_RX_STAT: rdata = status_word(rx_full, rx_empty);
                OFS_IRQ_EN:  rdata = {{(DATA_W-1){1'b0}}, irq_en};
                OFS_TX_STAT: rdata = status_word(tx_full, tx_empty);
                default:     rdata = '0;
            endcase
        end
    end

    a_r7_enable_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit && addr == OFS_IRQ_EN && wdata[0] && !rx_empty |=> irq);
    a_r5_empty_read_keeps_last: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit && addr == OFS_RX && rx_empty |=> $stable(last_rx));
    a_r6_status_read_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit && addr != OFS_RX |-> !rx_pop);
endmodule

// File: rtl/mbx_doorbell.sv
// Top of the two-way doorbell mailbox. Queue d is filled by port d and
// drained by the other port. Both ports share one register map and are
// always ready.
module mbx_doorbell
    import mbx_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p0_valid,
    input  logic              p0_write,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic [DATA_W-1:0] p0_wdata,
    output logic              p0_ready,
    output logic [DATA_W-1:0] p0_rdata,
    output logic              p0_irq,
    input  logic              p1_valid,
    input  logic              p1_write,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic [DATA_W-1:0] p1_wdata,
    output logic              p1_ready,
    output logic [DATA_W-1:0] p1_rdata,
    output logic              p1_irq
);
    localparam int unsigned NSIDE = 2;

    logic              s_valid [NSIDE];
    logic              s_write [NSIDE];
    logic [ADDR_W-1:0] s_addr  [NSIDE];
    logic [DATA_W-1:0] s_wdata [NSIDE];
    logic [DATA_W-1:0] s_rdata [NSIDE];
    logic              s_irq   [NSIDE];
    logic              q_push  [NSIDE];
    logic [DATA_W-1:0] q_wdata [NSIDE];
    logic              s_pop   [NSIDE];
    logic [DATA_W-1:0] q_head  [NSIDE];
    logic              q_full  [NSIDE];
    logic              q_empty [NSIDE];

    assign s_valid[0] = p0_valid;
    assign s_write[0] = p0_write;
    assign s_addr[0]  = p0_addr;
    assign s_wdata[0] = p0_wdata;
    assign s_valid[1] = p1_valid;
    assign s_write[1] = p1_write;
    assign s_addr[1]  = p1_addr;
    assign s_wdata[1] = p1_wdata;

    assign p0_ready = 1'b1;
    assign p1_ready = 1'b1;
    assign p0_rdata = s_rdata[0];
    assign p1_rdata = s_rdata[1];
    assign p0_irq   = s_irq[0];
    assign p1_irq   = s_irq[1];

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        mbx_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (q_push[s]),
            .push_data (q_wdata[s]),
            .pop       (s_pop[NSIDE-1-s]),
            .head      (q_head[s]),
            .full      (q_full[s]),
            .empty     (q_empty[s])
        );

        mbx_port u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .valid    (s_valid[s]),
            .write    (s_write[s]),
            .addr     (s_addr[s]),
            .wdata    (s_wdata[s]),
            .rdata    (s_rdata[s]),
            .rx_head  (q_head[NSIDE-1-s]),
            .rx_full  (q_full[NSIDE-1-s]),
            .rx_empty (q_empty[NSIDE-1-s]),
            .tx_full  (q_full[s]),
            .tx_empty (q_empty[s]),
            .rx_pop   (s_pop[s]),
            .tx_push  (q_push[s]),
            .tx_data  (q_wdata[s]),
            .irq      (s_irq[s])
        );
    end
endmodule

// File: tb/mbx_doorbell_tb_top.sv
module mbx_doorbell_tb_top;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        p0_valid = 0, p0_write = 0, p1_valid = 0, p1_write = 0;
    logic [7:0]  p0_addr = 0, p1_addr = 0;
    logic [31:0] p0_wdata = 0, p1_wdata = 0;
    logic        p0_ready, p1_ready, p0_irq, p1_irq;
    logic [31:0] p0_rdata, p1_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0] mq0[$];
    logic [31:0] mq1[$];
    logic [31:0] last_rx [2];

    always #5 clk = ~clk;

    mbx_doorbell #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .p0_valid(p0_valid), .p0_write(p0_write), .p0_addr(p0_addr), .p0_wdata(p0_wdata),
        .p0_ready(p0_ready), .p0_rdata(p0_rdata), .p0_irq(p0_irq),
        .p1_valid(p1_valid), .p1_write(p1_write), .p1_addr(p1_addr), .p1_wdata(p1_wdata),
        .p1_ready(p1_ready), .p1_rdata(p1_rdata), .p1_irq(p1_irq)
    );

    function automatic logic [31:0] st(input bit f, input bit e);
        return {f, e, 30'b0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // One bus request on one port; read data sampled mid-cycle.
    task automatic bus(input int side, input bit wr, input logic [7:0] a,
                       input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        if (side == 0) begin
            p0_valid = 1; p0_write = wr; p0_addr = a; p0_wdata = wd;
        end else begin
            p1_valid = 1; p1_write = wr; p1_addr = a; p1_wdata = wd;
        end
        #1;
        rd = (side == 0) ? p0_rdata : p1_rdata;
        @(posedge clk);
        #1;
        p0_valid = 0; p1_valid = 0;
    endtask

    function automatic int qsize(input int d);
        return (d == 0) ? mq0.size() : mq1.size();
    endfunction

    // Send on a port and update the model (drop when full).
    task automatic send(input int side, input logic [31:0] w);
        logic [31:0] rd;
        bus(side, 1, 8'h20, w, rd);
        if (qsize(side) < DEPTH) begin
            if (side == 0) mq0.push_back(w); else mq1.push_back(w);
        end
    endtask

    // Receive on a port and compare with the model.
    task automatic recv(input int side, input string tag, output logic [31:0] rd);
        logic [31:0] exp;
        int d;
        d = 1 - side;
        if (qsize(d) > 0) begin
            exp = (d == 0) ? mq0.pop_front() : mq1.pop_front();
            last_rx[side] = exp;
        end else begin
            exp = last_rx[side];
        end
        bus(side, 0, 8'h00, 0, rd);
        check(tag, rd, exp);
    endtask

    task automatic stat(input int side, input bit rxs, input string tag);
        logic [31:0] rd;
        int d;
        d = rxs ? 1 - side : side;
        bus(side, 0, rxs ? 8'h18 : 8'h38, 0, rd);
        check(tag, rd, st(qsize(d) == DEPTH, qsize(d) == 0));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] seed_dummy;
        last_rx[0] = 0;
        last_rx[1] = 0;
        seed_dummy = $urandom(32'h5eed_1234);
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        bus(0, 0, 8'h18, 0, rd); check("R1 p0 rx status", rd, 32'h4000_0000);
        bus(0, 0, 8'h38, 0, rd); check("R1 p0 tx status", rd, 32'h4000_0000);
        bus(1, 0, 8'h18, 0, rd); check("R1 p1 rx status", rd, 32'h4000_0000);
        bus(1, 0, 8'h38, 0, rd); check("R1 p1 tx status", rd, 32'h4000_0000);
        check("R1 irqs low", {30'b0, p0_irq, p1_irq}, 0);
        bus(0, 0, 8'h00, 0, rd); check("R1 R5 empty read after reset", rd, 0);
        check("R1 ready", {30'b0, p0_ready, p1_ready}, 32'h3);

        // R8: unmapped reads and ignored writes
        bus(0, 0, 8'h04, 0, rd); check("R8 unmapped read", rd, 0);
        bus(0, 1, 8'h00, 32'hDEAD_BEE1, rd);
        bus(0, 1, 8'h18, 32'hDEAD_BEE2, rd);
        bus(0, 1, 8'h44, 32'hDEAD_BEE3, rd);
        bus(1, 0, 8'h18, 0, rd); check("R8 writes ignored p1 rx", rd, 32'h4000_0000);
        bus(0, 0, 8'h38, 0, rd); check("R8 writes ignored p0 tx", rd, 32'h4000_0000);
        bus(1, 0, 8'h00, 0, rd); check("R8 no word delivered", rd, 0);

        // R3: channel-tagged words with software filtering for channel 8
        send(1, 32'h1000_0003);
        send(1, 32'h2000_0008);
        send(1, 32'h3000_0005);
        send(1, 32'h4000_0008);
        for (int k = 0; k < 2; k++) begin
            logic [31:0] got;
            int drops;
            drops = 0;
            got = 0;
            for (int g = 0; g < 8; g++) begin
                bus(0, 0, 8'h18, 0, rd);
                if (rd[30]) continue;
                recv(0, "R3 filtered read", got);
                if (got[3:0] == 4'h8) break;
                drops++;
            end
            check("R3 channel 8 word", got, (k == 0) ? 32'h2000_0008 : 32'h4000_0008);
            check("R3 address recovered", got & 32'hFFFF_FFF0, (k == 0) ? 32'h2000_0000 : 32'h4000_0000);
            check("R3 one discard", drops, 1);
        end
        stat(0, 1, "R2 R6 empty after filtering");

        // R4: fill, overflow drop, drain
        for (int k = 0; k < DEPTH + 1; k++) send(0, 32'hA000_0000 + (k << 4) + 8);
        bus(0, 0, 8'h38, 0, rd); check("R4 R2 full on sender", rd, 32'h8000_0000);
        bus(1, 0, 8'h18, 0, rd); check("R4 R2 full on receiver", rd, 32'h8000_0000);
        bus(1, 0, 8'h1C, 0, rd); check("R6 enable read no pop", rd, 0);
        bus(1, 0, 8'h18, 0, rd); check("R6 status read no pop", rd, 32'h8000_0000);
        for (int k = 0; k < DEPTH; k++) recv(1, "R4 drain order", rd);
        check("R4 last kept word", rd, 32'hA000_0078);
        bus(1, 0, 8'h00, 0, rd); check("R5 empty read returns last", rd, 32'hA000_0078);
        bus(1, 0, 8'h18, 0, rd); check("R5 still empty", rd, 32'h4000_0000);

        // R7: interrupt enable and not-empty interrupt
        bus(1, 1, 8'h1C, 32'hFFFF_FFFF, rd);
        bus(1, 0, 8'h1C, 0, rd); check("R7 enable readback", rd, 1);
        check("R7 irq low while empty", {31'b0, p1_irq}, 0);
        send(0, 32'h5550_0008);
        check("R7 irq high after push", {31'b0, p1_irq}, 1);
        check("R7 other port irq low", {31'b0, p0_irq}, 0);
        recv(1, "R7 pop", rd);
        check("R7 irq low after drain", {31'b0, p1_irq}, 0);
        send(0, 32'h6660_0008);
        bus(1, 1, 8'h1C, 0, rd);
        check("R7 irq masked", {31'b0, p1_irq}, 0);
        recv(1, "R7 pop masked", rd);

        // R9: same-cycle push and pop on a full queue, then on a one-word queue
        for (int k = 0; k < DEPTH; k++) send(0, 32'hB000_0001 + (k << 4));
        @(negedge clk);
        p0_valid = 1; p0_write = 1; p0_addr = 8'h20; p0_wdata = 32'hCCCC_CCC1;
        p1_valid = 1; p1_write = 0; p1_addr = 8'h00;
        #1 check("R9 pop data on full", p1_rdata, 32'hB000_0001);
        @(posedge clk); #1 p0_valid = 0; p1_valid = 0;
        void'(mq0.pop_front());
        last_rx[1] = 32'hB000_0001;
        bus(1, 0, 8'h18, 0, rd); check("R9 push dropped, not full", rd, 0);
        for (int k = 0; k < DEPTH - 1; k++) recv(1, "R9 drain", rd);
        check("R9 dropped word absent", rd, 32'hB000_0071);
        send(0, 32'hD000_0002);
        @(negedge clk);
        p0_valid = 1; p0_write = 1; p0_addr = 8'h20; p0_wdata = 32'hE000_0003;
        p1_valid = 1; p1_write = 0; p1_addr = 8'h00;
        #1 check("R9 pop on one-word queue", p1_rdata, 32'hD000_0002);
        @(posedge clk); #1 p0_valid = 0; p1_valid = 0;
        void'(mq0.pop_front());
        mq0.push_back(32'hE000_0003);
        last_rx[1] = 32'hD000_0002;
        recv(1, "R9 push kept", rd);

        // Random traffic against the model
        for (int n = 0; n < 800; n++) begin
            int side, op;
            side = $urandom_range(0, 1);
            op = $urandom_range(0, 3);
            case (op)
                0, 1: send(side, {$urandom_range(0, 32'h0FFF_FFFF), 4'($urandom_range(0, 15))});
                2: recv(side, "R3 R5 random read", rd);
                default: stat(side, $urandom_range(0, 1) == 1, "R2 random status");
            endcase
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule